// File: doc/BRIEF.md
# Monitor Group 1 Enable Register with Access Gating

This block holds the two Group 1 interrupt enable bits of one processor's interrupt CPU interface, one bit for the Secure state and one for the Non-secure state. Software reaches the bits through a coprocessor-style register access port. Each access that carries the block's own encoding receives exactly one verdict. The access either completes, is reported undefined, or traps to the hypervisor level. The verdict depends on the current exception level, on whether the needed features are present, on the hypervisor configuration and on the monitor's system-register enable.

The same two bits are also visible through a pair of single-bit alias ports, one per security state. These ports share the storage of the main register. Writes from the main port take precedence over the alias ports when both arrive in the same cycle.

When an enable bit drops while a Group 1 interrupt of that security state is pending locally, the block emits a one-cycle release request for that state. The pending interrupt can then be forwarded to another processor.

Top module: `mgrp_enable_reg`

## Requirements
- R1: After reset both enable bits are 0, `resp_valid` is 0 and `release_req` is 0.
- R2: An access is accepted only when `acc_coproc`=15, `acc_opc1`=6, `acc_crn`=12, `acc_crm`=12 and `acc_opc2`=7, for reads and writes alike. Any other access produces no response and leaves the enable bits unchanged.
- R3: When `feat_present` is 0, every accepted access is undefined, whatever the other inputs are.
- R4: An accepted access with `cur_el`=0 or `cur_el`=2 is undefined.
- R5: An accepted access with `cur_el`=1 traps when `el2_enabled` and `hyp_trap_en` are both 1. The trap is `resp_trap64` when `el2_is_a64`=1 and `resp_trap32` otherwise, with `resp_syndrome`=0x03. Every other `cur_el`=1 case is undefined. `resp_syndrome` is 0 whenever no trap is reported.
- R6: An accepted access with `cur_el`=3 is undefined when `mon_sreg_en`=0 and completes (`resp_ok`) otherwise. A completed read returns the register on `resp_rdata`, and a completed write loads it from `acc_wdata`.
- R7: The response is registered and appears in the single cycle after the access. On a response exactly one of `resp_ok`, `resp_undef`, `resp_trap64` and `resp_trap32` is 1. The register changes through the main port only when the verdict is ok.
- R8: Register layout: bit 1 is the Secure Group 1 enable and bit 0 is the Non-secure Group 1 enable, with 1 meaning enabled. Bits 31:2 ignore writes and read as 0.
- R9: `alias_we[1]`/`alias_wdata[1]`/`alias_rdata[1]` form the Secure view of bit 1. `alias_we[0]`/`alias_wdata[0]`/`alias_rdata[0]` form the Non-secure view of bit 0. Alias writes act at the next clock edge, and alias reads always show the stored bits.
- R10: When a completing main-port write and an alias write occur in the same cycle, the main-port value is stored.
- R11: When enable bit i goes from 1 to 0 and `pend_grp1[i]` is 1 in the following cycle, `release_req[i]` is high for exactly that one following cycle. It is never raised without such a fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write form, 0 = read form |
| acc_coproc | input | 4 | Coprocessor number of the access |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cur_el | input | 2 | Exception level of the access |
| feat_present | input | 1 | Required architecture features implemented |
| el2_enabled | input | 1 | Hypervisor level enabled |
| el2_is_a64 | input | 1 | Hypervisor level runs 64-bit state |
| hyp_trap_en | input | 1 | Hypervisor trap control for this register group |
| mon_sreg_en | input | 1 | Monitor system-register interface enable |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_ok | output | 1 | Access completed |
| resp_undef | output | 1 | Access undefined |
| resp_trap64 | output | 1 | Trap to hypervisor, 64-bit form |
| resp_trap32 | output | 1 | Trap to hypervisor, 32-bit form |
| resp_syndrome | output | 6 | Trap syndrome code |
| resp_rdata | output | 32 | Read data of a completed read |
| alias_we | input | 2 | Alias write enables (1 Secure, 0 Non-secure) |
| alias_wdata | input | 2 | Alias write values |
| alias_rdata | output | 2 | Alias read values |
| pend_grp1 | input | 2 | Group 1 interrupt pending locally, per state |
| release_req | output | 2 | Release pulse, per state |
| grp_en | output | 2 | Current enable bits |

## Verification
Every main-port verdict, its syndrome and its read data are due one clock edge after the access. The new enable value, seen on `grp_en` and `alias_rdata`, lands at that same edge, and so does an alias write. A release pulse comes one edge later still and lasts a single cycle. The bench drives each access at a falling edge and samples at the next falling edge, so it reads the result of the single rising edge between them. For release it checks three falling edges in a row: low, high, low again. This confirms both the extra cycle of delay and the pulse width.

// File: rtl/mgrp_pkg.sv
package mgrp_pkg;

    typedef enum logic [1:0] {
        OUT_OK     = 2'd0,
        OUT_UNDEF  = 2'd1,
        OUT_TRAP64 = 2'd2,
        OUT_TRAP32 = 2'd3
    } outcome_e;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } level_e;

endpackage

// File: rtl/mgrp_access_decode.sv
module mgrp_access_decode
    import mgrp_pkg::*;
#(
    parameter int unsigned CP_W    = 4,
    parameter int unsigned OPC1_W  = 3,
    parameter int unsigned CRN_W   = 4,
    parameter int unsigned CRM_W   = 4,
    parameter int unsigned OPC2_W  = 3,
    parameter logic [CP_W-1:0]   CP_NUM   = 4'd15,
    parameter logic [OPC1_W-1:0] OPC1_NUM = 3'd6,
    parameter logic [CRN_W-1:0]  CRN_NUM  = 4'd12,
    parameter logic [CRM_W-1:0]  CRM_NUM  = 4'd12,
    parameter logic [OPC2_W-1:0] OPC2_NUM = 3'd7
) (
    input  logic              acc_valid,
    input  logic [CP_W-1:0]   acc_coproc,
    input  logic [OPC1_W-1:0] acc_opc1,
    input  logic [CRN_W-1:0]  acc_crn,
    input  logic [CRM_W-1:0]  acc_crm,
    input  logic [OPC2_W-1:0] acc_opc2,
    input  logic [1:0]        cur_el,
    input  logic              feat_present,
    input  logic              el2_enabled,
    input  logic              el2_is_a64,
    input  logic              hyp_trap_en,
    input  logic              mon_sreg_en,
    output logic              hit,
    output outcome_e          outcome
);

    logic enc_match;

    always_comb begin
        enc_match = (acc_coproc == CP_NUM)  && (acc_opc1 == OPC1_NUM) &&
                    (acc_crn    == CRN_NUM) && (acc_crm  == CRM_NUM)  &&
                    (acc_opc2   == OPC2_NUM);
        hit = acc_valid && enc_match;
    end

    // Privilege and trap decision tree; the feature check dominates.
    always_comb begin
        outcome = OUT_UNDEF;
        if (feat_present) begin
            unique case (level_e'(cur_el))
                LVL1: begin
                    if (el2_enabled && hyp_trap_en)
                        outcome = el2_is_a64 ? OUT_TRAP64 : OUT_TRAP32;
                end
                LVL3: begin
                    if (mon_sreg_en)
                        outcome = OUT_OK;
                end
                default: outcome = OUT_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/mgrp_enable_store.sv
module mgrp_enable_store #(
    parameter int unsigned NUM_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_we,
    input  logic [NUM_ST-1:0] main_wbits,
    input  logic [NUM_ST-1:0] alias_we,
    input  logic [NUM_ST-1:0] alias_wdata,
    output logic [NUM_ST-1:0] en
);

    typedef struct packed {
        logic [NUM_ST-1:0] en;
    } store_t;

    store_t st_d, st_q;

    // Per-bit arbitration: main port first, then the alias view.
    for (genvar i = 0; i < NUM_ST; i++) begin : g_bit
        always_comb begin
            if (main_we)
                st_d.en[i] = main_wbits[i];
            else if (alias_we[i])
                st_d.en[i] = alias_wdata[i];
            else
                st_d.en[i] = st_q.en[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en = st_q.en;

endmodule

// File: rtl/mgrp_release_gen.sv
module mgrp_release_gen #(
    parameter int unsigned NUM_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_ST-1:0] en,
    input  logic [NUM_ST-1:0] pend,
    output logic [NUM_ST-1:0] rel
);

    typedef struct packed {
        logic [NUM_ST-1:0] en_prev;
        logic [NUM_ST-1:0] rel;
    } rel_t;

    rel_t r_d, r_q;

    for (genvar i = 0; i < NUM_ST; i++) begin : g_state
        always_comb begin
            r_d.en_prev[i] = en[i];
            r_d.rel[i]     = r_q.en_prev[i] && !en[i] && pend[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign rel = r_q.rel;

endmodule

// File: rtl/mgrp_enable_reg.sv
module mgrp_enable_reg
    import mgrp_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_ST    = 2,
    parameter int unsigned SYND_W    = 6,
    parameter logic [SYND_W-1:0] TRAP_SYND = 6'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_coproc,
    input  logic [2:0]        acc_opc1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_opc2,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cur_el,
    input  logic              feat_present,
    input  logic              el2_enabled,
    input  logic              el2_is_a64,
    input  logic              hyp_trap_en,
    input  logic              mon_sreg_en,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              resp_undef,
    output logic              resp_trap64,
    output logic              resp_trap32,
    output logic [SYND_W-1:0] resp_syndrome,
    output logic [DATA_W-1:0] resp_rdata,
    input  logic [NUM_ST-1:0] alias_we,
    input  logic [NUM_ST-1:0] alias_wdata,
    output logic [NUM_ST-1:0] alias_rdata,
    input  logic [NUM_ST-1:0] pend_grp1,
    output logic [NUM_ST-1:0] release_req,
    output logic [NUM_ST-1:0] grp_en
);

    localparam int unsigned RSV_W = DATA_W - NUM_ST;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic              undef;
        logic              trap64;
        logic              trap32;
        logic [SYND_W-1:0] synd;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    logic              hit;
    outcome_e          outcome;
    logic              main_we;
    logic [NUM_ST-1:0] en;
    logic              unused_rsv_wbits;
    resp_t             rsp_d, rsp_q;

    mgrp_access_decode u_dec (
        .acc_valid    (acc_valid),
        .acc_coproc   (acc_coproc),
        .acc_opc1     (acc_opc1),
        .acc_crn      (acc_crn),
        .acc_crm      (acc_crm),
        .acc_opc2     (acc_opc2),
        .cur_el       (cur_el),
        .feat_present (feat_present),
        .el2_enabled  (el2_enabled),
        .el2_is_a64   (el2_is_a64),
        .hyp_trap_en  (hyp_trap_en),
        .mon_sreg_en  (mon_sreg_en),
        .hit          (hit),
        .outcome      (outcome)
    );

    assign main_we          = hit && acc_write && (outcome == OUT_OK);
    assign unused_rsv_wbits = ^acc_wdata[DATA_W-1:NUM_ST];

    mgrp_enable_store #(.NUM_ST(NUM_ST)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_we     (main_we),
        .main_wbits  (acc_wdata[NUM_ST-1:0]),
        .alias_we    (alias_we),
        .alias_wdata (alias_wdata),
        .en          (en)
    );

    mgrp_release_gen #(.NUM_ST(NUM_ST)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .pend  (pend_grp1),
        .rel   (release_req)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = hit;
        if (hit) begin
            unique case (outcome)
                OUT_OK:     rsp_d.ok     = 1'b1;
                OUT_UNDEF:  rsp_d.undef  = 1'b1;
                OUT_TRAP64: rsp_d.trap64 = 1'b1;
                default:    rsp_d.trap32 = 1'b1;
            endcase
            if (outcome == OUT_TRAP64 || outcome == OUT_TRAP32)
                rsp_d.synd = TRAP_SYND;
            if (outcome == OUT_OK && !acc_write)
                rsp_d.rdata = {{RSV_W{1'b0}}, en};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign resp_valid    = rsp_q.valid;
    assign resp_ok       = rsp_q.ok;
    assign resp_undef    = rsp_q.undef;
    assign resp_trap64   = rsp_q.trap64;
    assign resp_trap32   = rsp_q.trap32;
    assign resp_syndrome = rsp_q.synd;
    assign resp_rdata    = rsp_q.rdata;
    assign alias_rdata   = en;
    assign grp_en        = en;

endmodule

// File: rtl/mgrp_enable_reg_chk.sv
module mgrp_enable_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  cur_el,
    input logic        feat_present,
    input logic        resp_valid,
    input logic        resp_ok,
    input logic        resp_undef,
    input logic        resp_trap64,
    input logic        resp_trap32,
    input logic [5:0]  resp_syndrome,
    input logic [31:0] resp_rdata,
    input logic [1:0]  alias_we,
    input logic [1:0]  release_req,
    input logic [1:0]  grp_en
);

    // R7
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $countones({resp_ok, resp_undef, resp_trap64, resp_trap32}) == 1);

    // R2
    no_verdict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(resp_ok || resp_undef || resp_trap64 || resp_trap32));

    // R6
    ok_needs_monitor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> ($past(cur_el) == 2'd3 && $past(feat_present) && $past(acc_valid)));

    // R5
    trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_trap64 || resp_trap32) |-> resp_syndrome == 6'h03);

    // R8
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_rdata[31:2] == 30'd0);

    // R7
    en_change_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grp_en) |-> ($past(acc_valid && acc_write) || $past(|alias_we)));

    // R11
    release_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_req[0] |-> ($past(grp_en[0], 2) && !$past(grp_en[0])));

    // R11
    release_after_fall_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_req[1] |-> ($past(grp_en[1], 2) && !$past(grp_en[1])));

    // R11
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_req) |=> !(|(release_req & $past(release_req))));

endmodule

bind mgrp_enable_reg mgrp_enable_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .cur_el        (cur_el),
    .feat_present  (feat_present),
    .resp_valid    (resp_valid),
    .resp_ok       (resp_ok),
    .resp_undef    (resp_undef),
    .resp_trap64   (resp_trap64),
    .resp_trap32   (resp_trap32),
    .resp_syndrome (resp_syndrome),
    .resp_rdata    (resp_rdata),
    .alias_we      (alias_we),
    .release_req   (release_req),
    .grp_en        (grp_en)
);

// File: tb/sim_mgrp_enable_reg.sv
module sim_mgrp_enable_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_coproc = '0, acc_crn = '0, acc_crm = '0;
    logic [2:0]  acc_opc1 = '0, acc_opc2 = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  cur_el = '0;
    logic        feat_present = 1'b0, el2_enabled = 1'b0, el2_is_a64 = 1'b0;
    logic        hyp_trap_en = 1'b0, mon_sreg_en = 1'b0;
    logic        resp_valid, resp_ok, resp_undef, resp_trap64, resp_trap32;
    logic [5:0]  resp_syndrome;
    logic [31:0] resp_rdata;
    logic [1:0]  alias_we = '0, alias_wdata = '0, alias_rdata;
    logic [1:0]  pend_grp1 = '0, release_req, grp_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_en = 2'b00;

    always #10 clk = ~clk;

    mgrp_enable_reg u0 (.*);

    // Vector: el[11:10] feat[9] el2en[8] a64[7] trap[6] sre[5] wr[4] wd[3:2] exp[1:0]
    // exp: 0 ok, 1 undef, 2 trap64, 3 trap32
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'd0},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'd1},
        {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 2'd1},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 2'd1},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 2'd2},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'd3},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 2'd1},
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 2'd1},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 2'd1},
        {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd1},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 2'd0},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge; return at the next falling edge.
    task automatic access(input logic [1:0] el, input logic feat, input logic e2, input logic a64,
                          input logic trp, input logic sre, input logic wr,
                          input logic [31:0] wd, input logic good);
        @(negedge clk);
        cur_el = el; feat_present = feat; el2_enabled = e2; el2_is_a64 = a64;
        hyp_trap_en = trp; mon_sreg_en = sre; acc_write = wr; acc_wdata = wd;
        acc_coproc = 4'd15; acc_opc1 = 3'd6; acc_crn = 4'd12; acc_crm = 4'd12;
        acc_opc2 = good ? 3'd7 : 3'd6;
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 grp_en", {30'd0, grp_en}, 32'd0);
        chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
        chk("R1 release_req", {30'd0, release_req}, 32'd0);

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            logic [3:0]  exp_flags;
            v = VEC[i];
            access(v[11:10], v[9], v[8], v[7], v[6], v[5], v[4], {30'd0, v[3:2]}, 1'b1);
            exp_flags = 4'b1000 >> v[1:0];
            if (v[1:0] == 2'd0 && v[4]) exp_en = v[3:2];
            chk($sformatf("R7 valid vec%0d", i), {31'd0, resp_valid}, 32'd1);
            chk($sformatf("R3/R4/R5/R6 R7 verdict vec%0d", i),
                {28'd0, resp_ok, resp_undef, resp_trap64, resp_trap32}, {28'd0, exp_flags});
            chk($sformatf("R5 syndrome vec%0d", i), {26'd0, resp_syndrome},
                (v[1:0] >= 2'd2) ? 32'h3 : 32'h0);
            if (v[1:0] == 2'd0 && !v[4])
                chk($sformatf("R6 rdata vec%0d", i), resp_rdata, {30'd0, exp_en});
            chk($sformatf("R8 grp_en vec%0d", i), {30'd0, grp_en}, {30'd0, exp_en});
        end

        // R2 wrong encoding: no response, no change
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0);
        chk("R2 no response", {31'd0, resp_valid}, 32'd0);
        chk("R2 enables kept", {30'd0, grp_en}, {30'd0, exp_en});

        // R8 reserved bits ignored on write, read as zero
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFD, 1'b1);
        chk("R8 write low bits", {30'd0, grp_en}, 32'd1);
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b1);
        chk("R8 read reserved zero", resp_rdata, 32'd1);

        // R9 alias views
        @(negedge clk); alias_we = 2'b10; alias_wdata = 2'b10;
        @(negedge clk); alias_we = 2'b00;
        chk("R9 secure alias write", {30'd0, grp_en}, 32'd3);
        chk("R9 alias read", {30'd0, alias_rdata}, 32'd3);
        @(negedge clk); alias_we = 2'b01; alias_wdata = 2'b00;
        @(negedge clk); alias_we = 2'b00;
        chk("R9 ns alias write", {30'd0, grp_en}, 32'd2);
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b1);
        chk("R9 main read sees alias", resp_rdata, 32'd2);

        // R10 main wins over alias in the same cycle
        @(negedge clk);
        cur_el = 2'd3; feat_present = 1'b1; mon_sreg_en = 1'b1; acc_write = 1'b1;
        acc_wdata = 32'd1; acc_opc2 = 3'd7; acc_valid = 1'b1;
        alias_we = 2'b11; alias_wdata = 2'b10;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; alias_we = 2'b00;
        chk("R10 main wins", {30'd0, grp_en}, 32'd1);

        // R11 NS falls with pending: pulse one cycle later, one cycle wide
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd3, 1'b1);
        pend_grp1 = 2'b01;
        @(negedge clk); alias_we = 2'b01; alias_wdata = 2'b00;
        @(negedge clk); alias_we = 2'b00;
        chk("R11 not yet", {30'd0, release_req}, 32'd0);
        @(negedge clk);
        chk("R11 ns pulse", {30'd0, release_req}, 32'd1);
        @(negedge clk);
        chk("R11 ns pulse ends", {30'd0, release_req}, 32'd0);

        // R11 Secure falls via main port with pending
        pend_grp1 = 2'b10;
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 1'b1);
        chk("R11 s not yet", {30'd0, release_req}, 32'd0);
        @(negedge clk);
        chk("R11 s pulse", {30'd0, release_req}, 32'd2);
        @(negedge clk);
        chk("R11 s pulse ends", {30'd0, release_req}, 32'd0);

        // R11 fall without pending: no pulse
        pend_grp1 = 2'b00;
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd3, 1'b1);
        access(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 1'b1);
        @(negedge clk);
        chk("R11 no pend no pulse", {30'd0, release_req}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule